// File: doc/BRIEF.md
# Address-Latched Static Memory with Shared Data Port

This block is a 256-word by 4-bit static memory. An access begins when the active-low chip enable goes low. On that edge the block captures the address into an internal register, and it holds that address for the rest of the access. The address pins may then change, or carry a value meant for another device, without disturbing the access in progress.

Two active-low chip selects and an active-low write enable decide what the access does. With both selects low and the write enable low, the word on the data input is stored. With both selects low and the write enable high, the stored word is driven out and the output enable is raised. In any other case the data path stays idle.

The bidirectional data pins are split into three signals: a data input, a data output and an output enable. Outside the block, these can be joined to one shared bus through a tristate buffer. The output passes through a hold stage, so the last word read stays on the data output after the read ends. The cells are arranged as 32 rows of 32 bits. Five address bits pick the row and three pick a 4-bit column group. The storage needs no refresh.

Top module: `latched_sram`

## Requirements
- R1: Each of the 256 addresses stores its own 4-bit word. A word written at an address reads back unchanged, whatever was written at the other 255 addresses.
- R2: The address is captured on the clock edge where `ce_n` is first sampled low after being high. The data path becomes active one clock later. In the capturing cycle `dout_en` is 0.
- R3: While `ce_n` stays low, changes on `addr` do not change which word is read or written. All later cycles of the same access use the captured address.
- R4: A write takes place on a clock edge only when the access is active, `sel1_n` = 0, `sel2_n` = 0 and `we_n` = 0. If either select is 1, the stored word is unchanged.
- R5: While the access is active, `sel1_n` = 0, `sel2_n` = 0 and `we_n` = 1, `dout_en` is 1 and `dout` carries the word at the captured address in the same cycle.
- R6: `dout_en` is 0 during a write, while either select is 1, and while `ce_n` is 1.
- R7: While `ce_n` is 1, the block is in standby. Toggling `addr`, `we_n`, `din` and the selects changes no stored word.
- R8: While `dout_en` is 0, `dout` keeps the last word that was read.
- R9: After reset, `dout_en` is 0 and `dout` is 0.
- R10: Stored words are held through long idle periods with no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low; its falling edge captures the address |
| sel1_n | input | 1 | First chip select, active low |
| sel2_n | input | 1 | Second chip select, active low |
| we_n | input | 1 | Write enable, active low; 1 selects read |
| addr | input | 8 | Word address |
| din | input | 4 | Write data (inbound side of the shared bus) |
| dout | output | 4 | Read data (outbound side of the shared bus) |
| dout_en | output | 1 | Output enable for the bus driver, active high |

## Verification
The bench fills all 256 words twice. It uses two unrelated arithmetic patterns, so a stuck bit or an aliased row or column group shows up as a mismatch. On every access it moves the address pins to a different value after the capturing edge. This separates a captured address from one that follows the pins. Writes attempted with one select high, and pin activity during standby, are followed by read-back of the same word to show that the stored word is unchanged. A read held open for several cycles while the pins wander, and a read after a long idle gap, check that the captured address is held and that the contents persist.

// File: rtl/lsram_pkg.sv
package lsram_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 4;
  localparam int ROW_W  = 5;
  localparam int COL_W  = 3;
  localparam int ROWS   = 1 << ROW_W;
  localparam int COLS   = 1 << COL_W;
  localparam int LINE_W = COLS * DATA_W;

  // row field: the three top address bits above the two lowest
  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return {a[7:5], a[1:0]};
  endfunction

  // column group: the three middle address bits
  function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[4:2];
  endfunction
endpackage

// File: rtl/lsram_addr_latch.sv
module lsram_addr_latch #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic [AW-1:0] addr,
  output logic          capture,
  output logic          active,
  output logic [AW-1:0] addr_q
);
  logic ce_n_prev;
  logic armed;

  assign capture = ce_n_prev & ~ce_n;
  assign active  = armed & ~ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_prev <= 1'b1;
      armed     <= 1'b0;
      addr_q    <= '0;
    end else begin
      ce_n_prev <= ce_n;
      if (ce_n)         armed <= 1'b0;
      else if (capture) armed <= 1'b1;
      if (capture)      addr_q <= addr;
    end
  end
endmodule

// File: rtl/lsram_cell_matrix.sv
module lsram_cell_matrix #(
  parameter int ROW_W = 5,
  parameter int COL_W = 3,
  parameter int DW    = 4
) (
  input  logic                   clk,
  input  logic                   gate,
  input  logic [ROW_W-1:0]       row,
  input  logic [COL_W-1:0]       col,
  input  logic                   wr,
  input  logic [DW-1:0]          din,
  output logic [(1<<ROW_W)-1:0]  row_hot,
  output logic [DW-1:0]          rdata
);
  localparam int ROWS   = 1 << ROW_W;
  localparam int LINE_W = (1 << COL_W) * DW;

  logic [LINE_W-1:0] lines [ROWS];
  logic [LINE_W-1:0] picked;

  // gated one-hot row decoder
  always_comb begin
    row_hot = '0;
    if (gate) row_hot[row] = 1'b1;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [LINE_W-1:0] line;
    always_ff @(posedge clk) begin
      if (wr && row_hot[r]) line[col*DW +: DW] <= din;
    end
    assign lines[r] = line;
  end

  always_comb begin
    picked = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (row_hot[r]) picked = picked | lines[r];
    end
  end

  assign rdata = picked[col*DW +: DW];
endmodule

// File: rtl/lsram_out_latch.sv
module lsram_out_latch #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_i,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held <= '0;
    else if (open_i) held <= d;
  end

  assign q = open_i ? d : held;
endmodule

// File: rtl/latched_sram.sv
module latched_sram
  import lsram_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          sel1_n,
  input  logic          sel2_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  logic            capture;
  logic            active;
  logic [AW-1:0]   addr_q;
  logic            selected;
  logic            wr_fire;
  logic            rd_fire;
  logic [ROWS-1:0] row_hot;
  logic [DW-1:0]   rdata;

  lsram_addr_latch #(.AW(AW)) u_alat (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .addr(addr),
    .capture(capture), .active(active), .addr_q(addr_q)
  );

  assign selected = active & ~sel1_n & ~sel2_n;
  assign wr_fire  = selected & ~we_n;
  assign rd_fire  = selected & we_n;

  lsram_cell_matrix #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u_cells (
    .clk(clk), .gate(active), .row(row_of(addr_q)), .col(col_of(addr_q)),
    .wr(wr_fire), .din(din), .row_hot(row_hot), .rdata(rdata)
  );

  lsram_out_latch #(.DW(DW)) u_olat (
    .clk(clk), .rst_n(rst_n), .open_i(rd_fire), .d(rdata), .q(dout)
  );

  assign dout_en = rd_fire;
endmodule

// File: rtl/latched_sram_chk.sv
module latched_sram_chk #(
  parameter int AW = 8,
  parameter int DW = 4,
  parameter int NR = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          sel1_n,
  input logic          sel2_n,
  input logic          we_n,
  input logic          dout_en,
  input logic [DW-1:0] dout,
  input logic          capture,
  input logic [AW-1:0] addr_q,
  input logic          wr_fire,
  input logic [NR-1:0] row_hot
);
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(addr_q));
  // R2
  capture_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !dout_en);
  // R6
  standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en);
  // R5
  read_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!ce_n && !sel1_n && !sel2_n && we_n));
  // R4
  write_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (!ce_n && !sel1_n && !sel2_n && !we_n && !dout_en));
  // R1
  one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_hot));
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dout_en && $past(!dout_en)) |-> $stable(dout));
endmodule

bind latched_sram latched_sram_chk #(.AW(AW), .DW(DW), .NR(lsram_pkg::ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sel1_n(sel1_n), .sel2_n(sel2_n),
  .we_n(we_n), .dout_en(dout_en), .dout(dout), .capture(capture),
  .addr_q(addr_q), .wr_fire(wr_fire), .row_hot(row_hot)
);

// File: tb/sim_latched_sram.sv
module sim_latched_sram;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, sel1_n = 1'b1, sel2_n = 1'b1, we_n = 1'b1;
  logic [7:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] dout;
  logic       dout_en;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] model [256];

  always #(CLK_P/2) clk = ~clk;

  latched_sram u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sel1_n(sel1_n), .sel2_n(sel2_n),
    .we_n(we_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] pat_a(input int a);
    return 4'((a * 7 + 3) % 16);
  endfunction

  function automatic logic [3:0] pat_b(input int a);
    return 4'(~a) ^ 4'(a >> 4);
  endfunction

  // full write access; the address pins move after the capturing edge
  task automatic wr(input logic [7:0] a, input logic [3:0] d, input logic s1, input logic s2);
    ce_n = 1'b0; we_n = 1'b0; sel1_n = s1; sel2_n = s2; addr = a; din = d;
    step();
    addr = ~a;
    step();
    ce_n = 1'b1; we_n = 1'b1; sel1_n = 1'b1; sel2_n = 1'b1;
    step();
  endtask

  task automatic rd(input logic [7:0] a, output logic [3:0] q, output logic en);
    ce_n = 1'b0; we_n = 1'b1; sel1_n = 1'b0; sel2_n = 1'b0; addr = a;
    #2;
    check("R2 no output in capture cycle", {3'b0, dout_en}, 4'h0);
    step();
    addr = a ^ 8'h5A;
    #1;
    q = dout; en = dout_en;
    step();
    ce_n = 1'b1;
    step();
  endtask

  logic [3:0] q;
  logic       en;

  initial begin
    #(CLK_P * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    step(); step();
    // R9
    check("R9 reset dout_en", {3'b0, dout_en}, 4'h0);
    check("R9 reset dout", dout, 4'h0);
    rst_n = 1'b1;
    step();

    // R1, R3: first pattern over every address
    for (int a = 0; a < 256; a++) begin
      wr(8'(a), pat_a(a), 1'b0, 1'b0);
      model[a] = pat_a(a);
    end
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), q, en);
      check("R1 R3 read pattern A", q, model[a]);
      // R5
      check("R5 read enable", {3'b0, en}, 4'h1);
    end

    // R1: second, unrelated pattern
    for (int a = 0; a < 256; a++) begin
      wr(8'(a), pat_b(a), 1'b0, 1'b0);
      model[a] = pat_b(a);
    end
    for (int a = 255; a >= 0; a--) begin
      rd(8'(a), q, en);
      check("R1 read pattern B", q, model[a]);
    end

    // R6: no output during an active write
    ce_n = 1'b0; we_n = 1'b0; sel1_n = 1'b0; sel2_n = 1'b0; addr = 8'h21; din = model[8'h21];
    step(); step();
    check("R6 write keeps dout_en low", {3'b0, dout_en}, 4'h0);
    ce_n = 1'b1; we_n = 1'b1; step();

    // R4: a write with one select high leaves the word intact
    wr(8'h3C, ~model[8'h3C], 1'b1, 1'b0);
    wr(8'hC3, ~model[8'hC3], 1'b0, 1'b1);
    rd(8'h3C, q, en);
    check("R4 sel1 high blocks write", q, model[8'h3C]);
    rd(8'hC3, q, en);
    check("R4 sel2 high blocks write", q, model[8'hC3]);

    // R6, R8: a read with a select high has no output, and dout holds its value
    rd(8'h77, q, en);
    check("R5 read before deselect", q, model[8'h77]);
    ce_n = 1'b0; we_n = 1'b1; sel1_n = 1'b1; sel2_n = 1'b0; addr = 8'h10;
    step(); step();
    check("R6 deselected read dout_en", {3'b0, dout_en}, 4'h0);
    check("R8 dout holds last read", dout, model[8'h77]);
    ce_n = 1'b1; sel1_n = 1'b1; step();

    // R7: pin activity in standby stores nothing
    for (int i = 0; i < 16; i++) begin
      addr = 8'(i * 17); din = ~model[i * 17]; we_n = 1'b0; sel1_n = 1'b0; sel2_n = 1'b0;
      step();
      check("R6 standby dout_en", {3'b0, dout_en}, 4'h0);
      check("R8 standby dout hold", dout, model[8'h77]);
    end
    we_n = 1'b1; sel1_n = 1'b1; sel2_n = 1'b1; step();
    for (int i = 0; i < 16; i++) begin
      rd(8'(i * 17), q, en);
      check("R7 standby writes ignored", q, model[i * 17]);
    end

    // R3: a read held open for several cycles while the address wanders
    ce_n = 1'b0; we_n = 1'b1; sel1_n = 1'b0; sel2_n = 1'b0; addr = 8'h9E;
    step();
    for (int i = 0; i < 4; i++) begin
      addr = 8'(i * 31);
      #1;
      check("R3 held address long read", dout, model[8'h9E]);
      step();
    end
    ce_n = 1'b1; step();

    // R10: retention through a long idle gap
    repeat (2000) step();
    rd(8'hE5, q, en);
    check("R10 retention after idle", q, model[8'hE5]);
    rd(8'h02, q, en);
    check("R10 retention after idle", q, model[8'h02]);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule